// File: doc/BRIEF.md
# PHY register write handshake bridge

This block is a host-side control register through which software places single bytes into a small register file inside a PHY. Software writes one 32-bit control word holding a register address, a data byte and a request flag. The block then performs exactly one write on a simple PHY-side port, made of an address, a data byte and a one-cycle strobe, and optionally waits for a ready indication from the PHY.

Completion is reported through an acknowledge flag in the same control word, using a full four-phase handshake. Acknowledge rises once the PHY write is done and stays high for as long as software holds the request. After software drops the request, acknowledge returns low, and only then can a new write start. A request raised outside the idle phase is refused. The address and data are captured when the request rises, so software may rewrite the fields mid-transaction without disturbing the write in flight.

Top module: `phy_wr_bridge`

## Requirements
- R1: Read-back places the address field at bits [5:0], the data field at bits [15:8], the request flag at bit 24 and the acknowledge flag at bit 26. Each field shows the last value that software wrote to it.
- R2: Every other read-back bit is 0. Software writes to bit 26 have no effect on the acknowledge flag.
- R3: A 0-to-1 transition of the request flag while the block is idle produces exactly one PHY write, to the address and with the data carried in that same control word.
- R4: The PHY strobe is high for exactly one cycle per transaction, and the PHY address and data do not change in the cycle after it.
- R5: With the ready input enabled, acknowledge rises in the cycle after the first cycle in which ready is sampled high during the write. It stays high while the request flag remains 1.
- R6: Once software clears the request, acknowledge reads 0 within two cycles and the block returns to idle.
- R7: A request raised before the block is back in idle, including one re-raised right after clearing while acknowledge is still high, starts no write. Only a fresh 0-to-1 transition of the request in idle starts one.
- R8: Writes to the address or data fields during a transaction do not change the PHY address or data of that transaction.
- R9: A synchronous active-high reset clears all fields, the request and acknowledge flags and the strobe, and returns the block to idle. This holds even in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control-word write enable |
| reg_wdata | input | 32 | Control-word write value |
| reg_rdata | output | 32 | Control-word read-back |
| phy_addr | output | ADDR_W | PHY register address, held from capture |
| phy_wdata | output | DATA_W | PHY write data, held from capture |
| phy_wr | output | 1 | One-cycle PHY write strobe |
| phy_ready | input | 1 | PHY completion indication (used when USE_READY=1) |

## Verification
The bench builds the block with the default 6-bit address, 8-bit data and the ready input enabled. It drives ready from a PHY model that responds after a delay of 0 to 10 cycles, chosen per transaction. This covers both completion in the strobe cycle itself and long waits in the write phase. The long waits leave time to rewrite the fields and to apply reset mid-write. The extreme addresses 0 and 63 and the data values 0x00 and 0xFF are part of the vector table.

// File: rtl/phy_wr_bridge.sv
module phy_wr_bridge #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter bit USE_READY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_wr,
  input  logic              phy_ready
);
  localparam int DATA_LSB = 8;
  localparam int REQ_BIT  = 24;
  localparam int ACK_BIT  = 26;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_ACK_HI, S_ACK_LO} st_t;

  st_t               st;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  logic              req_q;
  logic              strobe_q;
  logic              wr_done;

  wire start = reg_we && reg_wdata[REQ_BIT] && !req_q && (st == S_IDLE);

  generate
    if (USE_READY) begin : g_rdy
      assign wr_done = phy_ready;
    end else begin : g_nordy
      assign wr_done = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      f_addr    <= '0;
      f_data    <= '0;
      req_q     <= 1'b0;
      strobe_q  <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
    end else begin
      strobe_q <= start;
      if (reg_we) begin
        f_addr <= reg_wdata[ADDR_W-1:0];
        f_data <= reg_wdata[DATA_LSB +: DATA_W];
        req_q  <= reg_wdata[REQ_BIT];
      end
      if (start) begin
        phy_addr  <= reg_wdata[ADDR_W-1:0];
        phy_wdata <= reg_wdata[DATA_LSB +: DATA_W];
      end
      case (st)
        S_IDLE:   if (start)   st <= S_WRITE;
        S_WRITE:  if (wr_done) st <= S_ACK_HI;
        S_ACK_HI: if (!req_q)  st <= S_ACK_LO;
        default:               st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[ADDR_W-1:0]          = f_addr;
    reg_rdata[DATA_LSB +: DATA_W]  = f_data;
    reg_rdata[REQ_BIT]             = req_q;
    reg_rdata[ACK_BIT]             = (st == S_ACK_HI);
  end

  assign phy_wr = strobe_q;
endmodule

// File: rtl/phy_wr_bridge_chk.sv
module phy_wr_bridge_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       reg_rdata,
  input logic [ADDR_W-1:0] phy_addr,
  input logic [DATA_W-1:0] phy_wdata,
  input logic              phy_wr
);
  localparam logic [31:0] USED = 32'h0500_FF00 | ((32'd1 << ADDR_W) - 32'd1);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~USED) == 32'd0);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    phy_wr |=> !phy_wr);

  p_strobe_stable_r4: assert property (@(posedge clk) disable iff (rst)
    phy_wr |=> ($stable(phy_addr) && $stable(phy_wdata)));

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[26] && reg_rdata[24]) |=> reg_rdata[26]);

  p_no_write_under_ack_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[26] |=> !phy_wr);

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (reg_rdata == 32'd0 && !phy_wr));
endmodule

bind phy_wr_bridge phy_wr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata),
  .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_wr(phy_wr));

// File: tb/sim_phy_wr_bridge.sv
module sim_phy_wr_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  phy_addr;
  logic [7:0]  phy_wdata;
  logic        phy_wr;
  logic        phy_ready = 1'b0;

  int compared = 0, mismatched = 0;
  int strobes = 0;
  logic [5:0] last_a;
  logic [7:0] last_d;
  logic pend = 1'b0;
  int cnt = 0, dly_cfg = 0;
  bit done = 1'b0;

  localparam logic [17:0] VEC [8] = '{
    {6'd0,  8'h00, 4'd0}, {6'd63, 8'hFF, 4'd0}, {6'd21, 8'hA5, 4'd3},
    {6'd42, 8'h5A, 4'd1}, {6'd1,  8'h80, 4'd7}, {6'd62, 8'h01, 4'd2},
    {6'd21, 8'h3C, 4'd0}, {6'd63, 8'h00, 4'd4}};

  always #10 clk = ~clk;

  phy_wr_bridge u0 (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_wr(phy_wr), .phy_ready(phy_ready));

  always @(negedge clk) begin
    if (phy_wr) begin
      strobes++; last_a = phy_addr; last_d = phy_wdata;
      pend = 1'b1; cnt = dly_cfg;
    end else if (pend && cnt > 0) cnt--;
    if (reg_rdata[26] || rst) pend = 1'b0;
    phy_ready = pend && cnt == 0;
  end

  function automatic logic [31:0] word(bit req, logic [5:0] a, logic [7:0] d);
    return {7'd0, req, 8'd0, d, 2'd0, a};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_ack(bit val, int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (reg_rdata[26] == val) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic transact(logic [5:0] a, logic [7:0] d, int dly, string r);
    bit ok;
    int s0 = strobes;
    dly_cfg = dly;
    wr(word(1, a, d));
    wait_ack(1'b1, dly + 6, ok);
    chk({r, " ack rises"}, 32'(ok), 32'd1);
    wr(word(0, a, d));
    wait_ack(1'b0, 3, ok);
    chk("R6 ack drops", 32'(ok), 32'd1);
    chk("R3 one strobe", strobes - s0, 32'd1);
    chk("R3 phy addr/data", {last_a, last_d}, {a, d});
  endtask

  initial begin
    bit ok;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset state", reg_rdata, 32'd0);

    for (int i = 0; i < 8; i++) begin
      transact(VEC[i][17:12], VEC[i][11:4], int'(VEC[i][3:0]), "R5");
      chk("R1 readback", reg_rdata, word(0, VEC[i][17:12], VEC[i][11:4]));
    end

    wr(32'hFEFF_FFFF);
    chk("R2 reserved zero, bit26 ignored", reg_rdata, 32'h0000_FF3F);
    wr(32'h0400_0000);
    chk("R2 bit26 write ignored", reg_rdata, 32'd0);

    // R5: ack waits for ready, then holds
    dly_cfg = 6; s0 = strobes;
    wr(word(1, 6'd9, 8'h99));
    repeat (4) @(negedge clk);
    chk("R5 no ack before ready", 32'(reg_rdata[26]), 32'd0);
    wait_ack(1'b1, 10, ok);
    // R2: writing bit26=0 with request held must not drop ack
    wr(word(1, 6'd9, 8'h99));
    repeat (3) @(negedge clk);
    chk("R5 ack held", 32'(reg_rdata[26]), 32'd1);

    // R7: clear then re-raise at once
    wr(word(0, 6'd9, 8'h99));
    wr(word(1, 6'd10, 8'h11));
    repeat (10) @(negedge clk);
    chk("R7 refused strobes", strobes - s0, 32'd1);
    chk("R7 ack low", 32'(reg_rdata[26]), 32'd0);
    wr(word(0, 6'd10, 8'h11));
    transact(6'd10, 8'h11, 0, "R7");

    // R8: field rewrite mid-transaction
    dly_cfg = 8; s0 = strobes;
    wr(word(1, 6'd33, 8'hC3));
    wr(word(1, 6'd2, 8'h24));
    wait_ack(1'b1, 15, ok);
    chk("R8 captured", {last_a, last_d}, {6'd33, 8'hC3});
    chk("R1 fields show rewrite", reg_rdata, 32'h0500_2402);
    wr(word(0, 6'd2, 8'h24));
    repeat (3) @(negedge clk);

    // R9: reset mid-write
    dly_cfg = 10;
    wr(word(1, 6'd7, 8'h77));
    repeat (2) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R9 mid-write reset", reg_rdata, 32'd0);
    transact(6'd44, 8'hE7, 1, "R9");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule